// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out the 16-bit memory address of a load or store operand. It is purely combinational. A 3-bit mode code selects how the address is formed. The inputs it draws on are the instruction immediates (a low byte and a high byte), the HL and DE register pairs of the active bank, the B and C byte registers, and the stack pointer. The outputs are the address, a one-hot flag that shows which mode produced it, an illegal-mode flag, and a misalignment flag for word accesses into the two fixed byte windows.

Two of the modes do not compute an address by plain addition.

- **Short direct window:** the 8-bit offset is placed into a 256-byte window from FE20H to FF1FH. Address bit 8 is set from the offset value, so offsets below 20H wrap to the top of the window.
- **Special-register page:** the offset lands in FF00H to FFFFH.

The bus cycle, stack pointer updates and instruction fetch belong to neighbouring logic. So does the choice between the two pointer sources in each mode, which that logic makes with a single select input.

Top module: `eag_top`

## Requirements
- R1: Mode code 0 (direct) gives `addr_o = {imm_hi_i, imm_lo_i}`, with the high byte taken from the second instruction byte.
- R2: Mode code 1 (short direct) sets `addr_o[15:9]` to all ones and `addr_o[7:0]` to `imm_lo_i`. `addr_o[8]` is 1 when `imm_lo_i` is 00H–1FH and 0 when it is 20H–FFH, so 1FH gives FF1FH, 20H gives FE20H, FFH gives FEFFH and 00H gives FF00H.
- R3: Mode code 2 (special register) gives `addr_o = FF00H + imm_lo_i`.
- R4: Mode code 3 (register indirect) gives DE when `pick_i` is 0 and HL when `pick_i` is 1.
- R5: Mode code 4 (based) gives `(HL + imm_lo_i) mod 10000H`, with the immediate zero-extended and the carry out of bit 15 dropped.
- R6: Mode code 5 (based indexed) gives `(HL + B) mod 10000H` when `pick_i` is 0 and `(HL + C) mod 10000H` when `pick_i` is 1, with the byte zero-extended.
- R7: Mode code 6 (stack) gives the stack pointer value.
- R8: Mode code 7 is illegal. It drives `addr_o` to 0000H, sets `illegal_o` to 1, and holds `mode_used_o` and `misalign_o` at 0.
- R9: `misalign_o` is 1 only when `word_i` is 1, the mode is short direct or special register, and `imm_lo_i[0]` is 1. In every other mode `word_i` has no effect on any output.
- R10: For each legal mode, `mode_used_o` has exactly bit n set, where n is the mode code, and `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Addressing-mode code (0..6 legal, 7 illegal) |
| word_i | input | 1 | Access is a 16-bit word |
| pick_i | input | 1 | Source pick: DE/HL for indirect, B/C for indexed |
| imm_lo_i | input | 8 | First instruction immediate byte (offset or address low byte) |
| imm_hi_i | input | 8 | Second instruction immediate byte (address high byte) |
| hl_i | input | 16 | HL register pair of the active bank |
| de_i | input | 16 | DE register pair of the active bank |
| b_i | input | 8 | B register |
| c_i | input | 8 | C register |
| sp_i | input | 16 | Stack pointer |
| addr_o | output | 16 | Effective address |
| mode_used_o | output | 7 | One-hot flag of the mode applied |
| illegal_o | output | 1 | Mode code is not legal |
| misalign_o | output | 1 | Word access at an odd window offset |

## Verification
The bench aims at the short-direct wrap point. Offsets 1FH and 20H straddle it, and 00H and FFH sit at its edges. A design that added a fixed base, or that compared against the wrong split, would land 00H–1FH in FE00H–FE1FH instead of FF00H–FF1FH.

HL is set near FFFFH for both adding modes. A design that kept the carry or sign-extended the byte would return a wrong or wider address there.

Word accesses with odd offsets are applied in every mode. This catches a misalignment flag that leaks outside the two windows. Code 7 is driven with non-zero operands, which shows an illegal mode that still passes an address through.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EA_ADDR_W    = 16;
    localparam int EA_OFF_W     = 8;
    localparam int EA_SPLIT     = 32;
    localparam int EA_NUM_MODES = 7;

    typedef enum logic [2:0] {
        EA_DIRECT = 3'd0,
        EA_SHORT  = 3'd1,
        EA_SFR    = 3'd2,
        EA_REGIND = 3'd3,
        EA_BASED  = 3'd4,
        EA_BIDX   = 3'd5,
        EA_STACK  = 3'd6,
        EA_BAD    = 3'd7
    } ea_mode_e;

    typedef struct packed {
        logic [EA_NUM_MODES-1:0] used;
        logic                    illegal;
    } ea_decode_t;

    function automatic logic is_window_mode(input ea_mode_e m);
        return (m == EA_SHORT) || (m == EA_SFR);
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
#(
    parameter int NUM_MODES = EA_NUM_MODES
) (
    input  ea_mode_e             mode,
    output logic [NUM_MODES-1:0] used,
    output logic                 illegal
);
    localparam int CODE_W = $bits(ea_mode_e);

    genvar i;
    generate
        for (i = 0; i < NUM_MODES; i++) begin : g_hot
            assign used[i] = (mode == ea_mode_e'(CODE_W'(i)));
        end
    endgenerate

    assign illegal = ~|used;
endmodule

// File: rtl/eag_window.sv
module eag_window #(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 8,
    parameter int SPLIT      = 32,
    parameter bit SHORT_FORM = 1'b1
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              word,
    output logic [ADDR_W-1:0] addr,
    output logic              misalign
);
    localparam int HI_W = ADDR_W - OFF_W;

    generate
        if (SHORT_FORM) begin : g_short
            logic wrap_up;
            assign wrap_up = (off < OFF_W'(SPLIT));
            assign addr    = {{(HI_W-1){1'b1}}, wrap_up, off};
        end else begin : g_page
            assign addr = {{HI_W{1'b1}}, off};
        end
    endgenerate

    assign misalign = word & off[0];
endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  idx,
    output logic [ADDR_W-1:0] sum
);
    localparam int PAD_W = ADDR_W - OFF_W;

    assign sum = base + {{PAD_W{1'b0}}, idx};
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W = EA_ADDR_W,
    parameter int OFF_W  = EA_OFF_W,
    parameter int SPLIT  = EA_SPLIT
) (
    input  logic [2:0]              mode_i,
    input  logic                    word_i,
    input  logic                    pick_i,
    input  logic [OFF_W-1:0]        imm_lo_i,
    input  logic [OFF_W-1:0]        imm_hi_i,
    input  logic [ADDR_W-1:0]       hl_i,
    input  logic [ADDR_W-1:0]       de_i,
    input  logic [OFF_W-1:0]        b_i,
    input  logic [OFF_W-1:0]        c_i,
    input  logic [ADDR_W-1:0]       sp_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [EA_NUM_MODES-1:0] mode_used_o,
    output logic                    illegal_o,
    output logic                    misalign_o
);
    localparam int DIR_PAD = ADDR_W - 2 * OFF_W;

    ea_mode_e    mode;
    ea_decode_t  dec;
    logic [ADDR_W-1:0] short_addr, sfr_addr, based_addr, bidx_addr, ptr_addr, dir_addr;
    logic              short_mis, sfr_mis;
    logic [OFF_W-1:0]  idx_byte;

    assign mode = ea_mode_e'(mode_i);

    eag_decode #(.NUM_MODES(EA_NUM_MODES)) u_dec (
        .mode    (mode),
        .used    (dec.used),
        .illegal (dec.illegal)
    );

    eag_window #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SPLIT(SPLIT), .SHORT_FORM(1'b1)) u_short (
        .off      (imm_lo_i),
        .word     (word_i),
        .addr     (short_addr),
        .misalign (short_mis)
    );

    eag_window #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SPLIT(SPLIT), .SHORT_FORM(1'b0)) u_sfr (
        .off      (imm_lo_i),
        .word     (word_i),
        .addr     (sfr_addr),
        .misalign (sfr_mis)
    );

    eag_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_based (
        .base (hl_i),
        .idx  (imm_lo_i),
        .sum  (based_addr)
    );

    assign idx_byte = pick_i ? c_i : b_i;

    eag_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_bidx (
        .base (hl_i),
        .idx  (idx_byte),
        .sum  (bidx_addr)
    );

    assign ptr_addr = pick_i ? hl_i : de_i;

    generate
        if (DIR_PAD > 0) begin : g_dir_pad
            assign dir_addr = {{DIR_PAD{1'b0}}, imm_hi_i, imm_lo_i};
        end else begin : g_dir_fit
            assign dir_addr = ADDR_W'({imm_hi_i, imm_lo_i});
        end
    endgenerate

    always_comb begin
        unique case (mode)
            EA_DIRECT: addr_o = dir_addr;
            EA_SHORT:  addr_o = short_addr;
            EA_SFR:    addr_o = sfr_addr;
            EA_REGIND: addr_o = ptr_addr;
            EA_BASED:  addr_o = based_addr;
            EA_BIDX:   addr_o = bidx_addr;
            EA_STACK:  addr_o = sp_i;
            default:   addr_o = '0;
        endcase
    end

    assign mode_used_o = dec.used;
    assign illegal_o   = dec.illegal;
    assign misalign_o  = (dec.used[EA_SHORT] & short_mis) |
                         (dec.used[EA_SFR]   & sfr_mis);
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic [2:0]              mode_i,
    input logic                    word_i,
    input logic [EA_ADDR_W-1:0]    addr_o,
    input logic [EA_NUM_MODES-1:0] mode_used_o,
    input logic                    illegal_o,
    input logic                    misalign_o
);
    always_comb begin
        // R8
        if (illegal_o) begin
            a_r8_illegal_quiet: assert (addr_o == '0 && mode_used_o == '0 && !misalign_o)
                else $error("R8 illegal mode left outputs active");
        end
        // R10
        a_r10_one_hot: assert ($onehot0(mode_used_o) && (illegal_o != (mode_used_o != '0)))
            else $error("R10 mode flag not one-hot");
        // R2
        if (mode_used_o[EA_SHORT]) begin
            a_r2_short_window: assert (addr_o >= 16'hFE20 && addr_o <= 16'hFF1F)
                else $error("R2 short address outside window");
        end
        // R3
        if (mode_used_o[EA_SFR]) begin
            a_r3_sfr_page: assert (addr_o[15:8] == 8'hFF)
                else $error("R3 special-register address off page");
        end
        // R9
        if (misalign_o) begin
            a_r9_misalign_cause: assert (word_i && addr_o[0] &&
                                         (mode_used_o[EA_SHORT] || mode_used_o[EA_SFR]))
                else $error("R9 misalign without cause");
        end
        if (mode_i == 3'd7) begin
            a_r8_code_seven: assert (illegal_o) else $error("R8 code 7 not flagged");
        end
    end
endmodule

bind eag_top eag_checker u_chk (
    .mode_i      (mode_i),
    .word_i      (word_i),
    .addr_o      (addr_o),
    .mode_used_o (mode_used_o),
    .illegal_o   (illegal_o),
    .misalign_o  (misalign_o)
);

// File: tb/tb_eag_top.sv
`timescale 1ns/1ps
module tb_eag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd0;
    logic        word_i = 1'b0;
    logic        pick_i = 1'b0;
    logic [7:0]  imm_lo_i = 8'h00, imm_hi_i = 8'h00, b_i = 8'h00, c_i = 8'h00;
    logic [15:0] hl_i = 16'h0, de_i = 16'h0, sp_i = 16'h0;
    logic [15:0] addr_o;
    logic [6:0]  mode_used_o;
    logic        illegal_o, misalign_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    eag_top dut (
        .mode_i(mode_i), .word_i(word_i), .pick_i(pick_i),
        .imm_lo_i(imm_lo_i), .imm_hi_i(imm_hi_i),
        .hl_i(hl_i), .de_i(de_i), .b_i(b_i), .c_i(c_i), .sp_i(sp_i),
        .addr_o(addr_o), .mode_used_o(mode_used_o),
        .illegal_o(illegal_o), .misalign_o(misalign_o)
    );

    // behavioural reference built from the requirements
    function automatic int ref_addr(input int m, input int pk, input int lo, input int hi,
                                    input int hl, input int de, input int b, input int c,
                                    input int sp);
        case (m)
            0: return hi * 256 + lo;
            1: return (lo >= 32) ? 65024 + lo : 65280 + lo;
            2: return 65280 + lo;
            3: return pk ? hl : de;
            4: return (hl + lo) % 65536;
            5: return (hl + (pk ? c : b)) % 65536;
            6: return sp;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp, input string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input int m, input bit w, input bit pk, input int lo, input int hi,
                         input int hl, input int de, input int b, input int c, input int sp);
        int ea, eu, emis;
        @(posedge clk);
        #1;
        mode_i = 3'(m); word_i = w; pick_i = pk;
        imm_lo_i = 8'(lo); imm_hi_i = 8'(hi);
        hl_i = 16'(hl); de_i = 16'(de); b_i = 8'(b); c_i = 8'(c); sp_i = 16'(sp);
        @(negedge clk);
        ea   = ref_addr(m, pk, lo, hi, hl, de, b, c, sp);
        eu   = (m < 7) ? (1 << m) : 0;
        emis = (w && (m == 1 || m == 2) && (lo % 2 == 1)) ? 1 : 0;
        check(tag_of(m), int'(addr_o), ea, "addr");
        check((m < 7) ? "R10" : "R8", int'(mode_used_o), eu, "mode flag");
        check((m < 7) ? "R10" : "R8", int'(illegal_o), (m == 7) ? 1 : 0, "illegal");
        check("R9", int'(misalign_o), emis, "misalign");
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle pattern after start: mode 0, all zero -> address 0000H
        check("R1", int'(addr_o), 0, "idle addr");
        check("R10", int'(mode_used_o), 1, "idle flag");

        // R1 direct
        apply(0, 0, 0, 'h00, 'hFE, 0, 0, 0, 0, 0);
        apply(0, 1, 1, 'h34, 'h12, 'hFFFF, 1, 2, 3, 4);
        // R2 short-direct boundaries
        apply(1, 0, 0, 'h1F, 0, 0, 0, 0, 0, 0);
        apply(1, 0, 0, 'h20, 0, 0, 0, 0, 0, 0);
        apply(1, 0, 0, 'hFF, 0, 0, 0, 0, 0, 0);
        apply(1, 0, 0, 'h00, 0, 0, 0, 0, 0, 0);
        apply(1, 1, 0, 'h1F, 0, 0, 0, 0, 0, 0);   // R9 odd word
        apply(1, 1, 0, 'h20, 0, 0, 0, 0, 0, 0);   // R9 even word
        // R3 special-register page
        apply(2, 0, 0, 'h00, 'h55, 0, 0, 0, 0, 0);
        apply(2, 1, 0, 'hFF, 0, 0, 0, 0, 0, 0);
        apply(2, 1, 0, 'h20, 0, 0, 0, 0, 0, 0);
        // R4 register indirect
        apply(3, 1, 0, 'h01, 0, 'h1234, 'hABCD, 0, 0, 0);
        apply(3, 1, 1, 'h01, 0, 'h1234, 'hABCD, 0, 0, 0);
        // R5 based with HL wrap
        apply(4, 0, 0, 'h10, 0, 'hFFFF, 0, 0, 0, 0);
        apply(4, 1, 0, 'hFF, 0, 'hFFF0, 0, 0, 0, 0);
        apply(4, 0, 0, 'h80, 0, 'h0100, 0, 0, 0, 0);
        // R6 based indexed
        apply(5, 0, 0, 0, 0, 'hFFFF, 0, 'h01, 'h90, 0);
        apply(5, 0, 1, 0, 0, 'hFFFF, 0, 'h01, 'h90, 0);
        apply(5, 1, 1, 'h03, 0, 'h00FF, 0, 'hFF, 'h80, 0);
        // R7 stack
        apply(6, 1, 0, 'h01, 0, 0, 0, 0, 0, 'hFE1E);
        // R8 illegal with busy operands
        apply(7, 1, 1, 'h1F, 'hFF, 'hFFFF, 'hFFFF, 'hFF, 'hFF, 'hFFFF);

        // sweep every offset through both window modes, word access (R2 R3 R9)
        for (int k = 0; k < 256; k++) begin
            apply(1, 1, 0, k, 0, 0, 0, 0, 0, 0);
            apply(2, 1, 0, k, 0, 0, 0, 0, 0, 0);
        end

        // mixed patterns in all codes
        for (int k = 0; k < 1500; k++) begin
            apply(int'($urandom_range(7, 0)), 1'($urandom), 1'($urandom),
                  int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
                  int'($urandom_range(65535, 0)), int'($urandom_range(65535, 0)),
                  int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
                  int'($urandom_range(65535, 0)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule